// File: doc/BRIEF.md
# Atomic Memory Sequencer

This block sits between a processor's load/store port and a single-ported memory of 32-bit words. It executes three kinds of requests: load-reserved (read a word and remember its address), store-conditional (write a word only while that address is still remembered), and read-modify-write atomics (read the old word, combine it with an operand, write the result back, and return the old word). Each atomic's read and write phases run back to back while the request port is closed, so no other access can come between them.

One reservation is kept. It is cleared by any store-conditional and by an external store reported on the snoop input. Each request carries ordering flags. The release flag holds the first memory access back until earlier writes, reported by `wr_pending`, have drained. The acquire flag keeps the request port closed through the response cycle. Without acquire, the port reopens in the response cycle so that the next request can be accepted there. Misaligned addresses and unknown operation codes complete at once with an error and never reach memory.

The controller is a single state machine with these states: IDLE, DRAIN (release wait), READ (read issued), CAPTURE (read data latched), CHECK (store-conditional decision), WRITE (write issued) and RESP (response cycle). Its transitions are:
- IDLE/RESP to RESP on an erroneous request;
- IDLE/RESP to DRAIN when release is set and writes are pending;
- IDLE/RESP/DRAIN to CHECK for a store-conditional, otherwise to READ;
- READ to CAPTURE;
- CAPTURE to RESP for a load-reserved, otherwise to WRITE;
- CHECK to WRITE on a reservation hit, otherwise to RESP;
- WRITE to RESP;
- RESP to IDLE when no request is accepted.

Top module: `amo_seq`

## Requirements
- R1: A load-reserved (op code 0) returns the addressed word on `rsp_data`, records a reservation on that word address, and raises `rsp_valid` on the 3rd rising edge counting the accepting edge as the 1st. It makes exactly one memory access, a read.
- R2: A store-conditional (op code 1) succeeds only while a reservation is held on the same word address. On success it writes `req_data` to memory, returns 0, responds on the 3rd edge and makes one memory access. On failure it returns 1, leaves memory unchanged, responds on the 2nd edge and makes no memory access.
- R3: Every store-conditional, whether it succeeds or fails, clears the reservation.
- R4: A snoop (`snoop_valid` high at a rising edge) whose word address equals the reserved one clears the reservation. A snoop to any other word address leaves the reservation in place.
- R5: A read-modify-write atomic returns the old word, writes f(old, `req_data`) to the same word, responds on the 4th edge, makes exactly two memory accesses and never issues two writes in consecutive cycles. The op codes are: 2 swap, 3 add (modulo 2^32), 4 and, 5 or, 6 xor, 7 signed min, 8 signed max, 9 unsigned min, 10 unsigned max.
- R6: Codes 7 and 8 compare the words as two's-complement numbers. Codes 9 and 10 compare them as unsigned numbers.
- R7: After a request is accepted, `req_ready` stays low until the response cycle. In the response cycle `req_ready` is high when acquire (`req_acq`) was clear and low when it was set. `rsp_valid` stays low until the response cycle.
- R8: When release (`req_rel`) is set and `wr_pending` is high at the accepting edge, no memory access occurs while `wr_pending` stays high. Each edge that sees `wr_pending` high after acceptance, plus one more, is added to the latency.
- R9: A request whose address has nonzero bits [1:0], or whose op code is 11 to 15, responds on the 1st edge after acceptance with `rsp_err` = 1 and `rsp_data` = 0. It makes no memory access and leaves the reservation unchanged.
- R10: During and straight after reset, `req_ready` = 1, `rsp_valid` = 0 and `mem_en` = 0, and no reservation is held, so the first store-conditional fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge if valid |
| req_op | input | 4 | Operation code |
| req_addr | input | 32 | Byte address |
| req_data | input | 32 | Source operand |
| req_acq | input | 1 | Acquire ordering flag |
| req_rel | input | 1 | Release ordering flag |
| wr_pending | input | 1 | Earlier writes not yet drained |
| rsp_valid | output | 1 | Response cycle |
| rsp_data | output | 32 | Value for the destination register |
| rsp_err | output | 1 | Misaligned address or unknown op |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write (read when low) |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| snoop_valid | input | 1 | External store observed |
| snoop_waddr | input | 30 | Word address of the external store |

## Verification
Every atomic function is applied to operand pairs that share a sign, pairs that differ in sign, and pairs that straddle the unsigned midpoint. Signed and unsigned min/max give different answers on these pairs, and add wraps past 2^32. Reservation sequences cover a matched store-conditional, a retry after success, a different address, a snoop to another word and a snoop to the reserved word. These show that clearing happens on the right event and only then. Latency, memory access counts and the `req_ready` value in the response cycle are compared against a bench model on every cycle, with acquire and release both set and clear and with a held `wr_pending`. These comparisons show that the phases are indivisible and that the ordering flags have their effect.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam logic [3:0] OP_LR   = 4'd0;
    localparam logic [3:0] OP_SC   = 4'd1;
    localparam logic [3:0] OP_SWAP = 4'd2;
    localparam logic [3:0] OP_ADD  = 4'd3;
    localparam logic [3:0] OP_AND  = 4'd4;
    localparam logic [3:0] OP_OR   = 4'd5;
    localparam logic [3:0] OP_XOR  = 4'd6;
    localparam logic [3:0] OP_MIN  = 4'd7;
    localparam logic [3:0] OP_MAX  = 4'd8;
    localparam logic [3:0] OP_MINU = 4'd9;
    localparam logic [3:0] OP_MAXU = 4'd10;
    localparam logic [3:0] OP_LAST = OP_MAXU;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRAIN,
        ST_READ,
        ST_CAPTURE,
        ST_CHECK,
        ST_WRITE,
        ST_RESP
    } amo_state_e;

endpackage

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [3:0]    op_i,
    input  logic [DW-1:0] old_i,
    input  logic [DW-1:0] opnd_i,
    output logic [DW-1:0] new_o
);
    logic lt_s;
    logic lt_u;

    always_comb begin
        lt_s = $signed(old_i) < $signed(opnd_i);
        lt_u = old_i < opnd_i;
        unique case (op_i)
            OP_ADD:  new_o = old_i + opnd_i;
            OP_AND:  new_o = old_i & opnd_i;
            OP_OR:   new_o = old_i | opnd_i;
            OP_XOR:  new_o = old_i ^ opnd_i;
            OP_MIN:  new_o = lt_s ? old_i : opnd_i;
            OP_MAX:  new_o = lt_s ? opnd_i : old_i;
            OP_MINU: new_o = lt_u ? old_i : opnd_i;
            OP_MAXU: new_o = lt_u ? opnd_i : old_i;
            default: new_o = opnd_i;
        endcase
    end
endmodule

// File: rtl/amo_req_chk.sv
module amo_req_chk
    import amo_pkg::*;
#(
    parameter int OFFW = 2
) (
    input  logic [OFFW-1:0] addr_lo_i,
    input  logic [3:0]      op_i,
    output logic            bad_o
);
    always_comb begin
        bad_o = (addr_lo_i != '0) || (op_i > OP_LAST);
    end
endmodule

// File: rtl/amo_resv.sv
module amo_resv #(
    parameter int WAW = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_i,
    input  logic           clr_i,
    input  logic [WAW-1:0] addr_i,
    input  logic           snoop_valid_i,
    input  logic [WAW-1:0] snoop_waddr_i,
    output logic           hit_o
);
    logic           held_q;
    logic [WAW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= 1'b0;
            addr_q <= '0;
        end else if (clr_i) begin
            held_q <= 1'b0;
        end else if (set_i) begin
            addr_q <= addr_i;
            held_q <= !(snoop_valid_i && snoop_waddr_i == addr_i);
        end else if (snoop_valid_i && snoop_waddr_i == addr_q) begin
            held_q <= 1'b0;
        end
    end

    assign hit_o = held_q && (addr_q == addr_i);
endmodule

// File: rtl/amo_seq.sv
module amo_seq
    import amo_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [3:0]       req_op,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_data,
    input  logic             req_acq,
    input  logic             req_rel,
    input  logic             wr_pending,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic             rsp_err,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic             snoop_valid,
    input  logic [AW-$clog2(DW/8)-1:0] snoop_waddr
);
    localparam int OFFW = $clog2(DW / 8);
    localparam int WAW  = AW - OFFW;

    amo_state_e     state, state_nx;
    logic [3:0]     op_q;
    logic [WAW-1:0] waddr_q;
    logic [DW-1:0]  opnd_q;
    logic [DW-1:0]  result_q;
    logic           acq_q;
    logic           err_q;
    logic           bad;
    logic           accept;
    logic           resv_hit;
    logic [DW-1:0]  alu_y;

    amo_req_chk #(.OFFW(OFFW)) u_chk_req (
        .addr_lo_i (req_addr[OFFW-1:0]),
        .op_i      (req_op),
        .bad_o     (bad)
    );

    amo_alu #(.DW(DW)) u_alu (
        .op_i   (op_q),
        .old_i  (result_q),
        .opnd_i (opnd_q),
        .new_o  (alu_y)
    );

    amo_resv #(.WAW(WAW)) u_resv (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_i         (state == ST_CAPTURE && op_q == OP_LR),
        .clr_i         (state == ST_CHECK),
        .addr_i        (waddr_q),
        .snoop_valid_i (snoop_valid),
        .snoop_waddr_i (snoop_waddr),
        .hit_o         (resv_hit)
    );

    assign accept = req_valid && req_ready;

    function automatic amo_state_e first_phase(input logic [3:0] op);
        return (op == OP_SC) ? ST_CHECK : ST_READ;
    endfunction

    function automatic amo_state_e start_state(input logic is_bad, input logic rel,
                                               input logic pend, input logic [3:0] op);
        if (is_bad)          return ST_RESP;
        else if (rel && pend) return ST_DRAIN;
        else                 return first_phase(op);
    endfunction

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (accept) state_nx = start_state(bad, req_rel, wr_pending, req_op);
            ST_DRAIN:   if (!wr_pending) state_nx = first_phase(op_q);
            ST_READ:    state_nx = ST_CAPTURE;
            ST_CAPTURE: state_nx = (op_q == OP_LR) ? ST_RESP : ST_WRITE;
            ST_CHECK:   state_nx = resv_hit ? ST_WRITE : ST_RESP;
            ST_WRITE:   state_nx = ST_RESP;
            ST_RESP:    state_nx = accept ? start_state(bad, req_rel, wr_pending, req_op)
                                          : ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q     <= '0;
            waddr_q  <= '0;
            opnd_q   <= '0;
            result_q <= '0;
            acq_q    <= 1'b0;
            err_q    <= 1'b0;
        end else if (accept) begin
            op_q     <= req_op;
            waddr_q  <= req_addr[AW-1:OFFW];
            opnd_q   <= req_data;
            acq_q    <= req_acq;
            err_q    <= bad;
            result_q <= '0;
        end else if (state == ST_CAPTURE) begin
            result_q <= mem_rdata;
        end else if (state == ST_CHECK) begin
            result_q <= resv_hit ? DW'(0) : DW'(1);
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        unique case (state)
            ST_IDLE:    req_ready = 1'b1;
            ST_READ:    mem_en = 1'b1;
            ST_WRITE: begin
                mem_en = 1'b1;
                mem_we = 1'b1;
            end
            ST_RESP: begin
                rsp_valid = 1'b1;
                req_ready = !acq_q;
            end
            default: ;
        endcase
        rsp_data  = result_q;
        rsp_err   = err_q;
        mem_addr  = {waddr_q, {OFFW{1'b0}}};
        mem_wdata = (op_q == OP_SC) ? opnd_q : alu_y;
    end
endmodule

// File: rtl/amo_seq_chk.sv
module amo_seq_chk #(
    parameter int OFFW = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            req_acq,
    input logic            req_rel,
    input logic [OFFW-1:0] req_addr_lo,
    input logic            wr_pending,
    input logic            rsp_valid,
    input logic            rsp_err,
    input logic            mem_en,
    input logic            mem_we
);
    logic accept;
    logic rel_wait;

    assign accept = req_valid && req_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              rel_wait <= 1'b0;
        else if (accept)                         rel_wait <= req_rel && wr_pending;
        else if (!wr_pending || mem_en || rsp_valid) rel_wait <= 1'b0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_R10: assert (req_ready && !rsp_valid && !mem_en);
        end
    end

    assert_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!req_ready || rsp_valid));

    assert_acq_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_acq) |=> !req_ready);

    assert_misalign_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_addr_lo != '0) |=> (rsp_valid && rsp_err && !mem_en));

    assert_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_wait && wr_pending) |-> !mem_en);

    assert_one_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);
endmodule

bind amo_seq amo_seq_chk #(.OFFW(OFFW)) u_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_acq     (req_acq),
    .req_rel     (req_rel),
    .req_addr_lo (req_addr[OFFW-1:0]),
    .wr_pending  (wr_pending),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .mem_en      (mem_en),
    .mem_we      (mem_we)
);

// File: tb/amo_seq_tb.sv
`timescale 1ns/1ps
module amo_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_op = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_data = '0;
    logic        req_acq = 1'b0;
    logic        req_rel = 1'b0;
    logic        wr_pending = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_err;
    logic        mem_en;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        snoop_valid = 1'b0;
    logic [29:0] snoop_waddr = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] mem [0:63];
    logic [31:0] ref_mem [0:63];
    bit          ref_held = 0;
    int          ref_idx = 0;

    always #2 clk = ~clk;

    amo_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .req_acq(req_acq), .req_rel(req_rel), .wr_pending(wr_pending),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .snoop_valid(snoop_valid), .snoop_waddr(snoop_waddr)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:2]];
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    function automatic logic [31:0] combine(input logic [3:0] op,
                                            input logic [31:0] a, input logic [31:0] b);
        case (op)
            4'd2:  return b;
            4'd3:  return a + b;
            4'd4:  return a & b;
            4'd5:  return a | b;
            4'd6:  return a ^ b;
            4'd7:  return ($signed(a) < $signed(b)) ? a : b;
            4'd8:  return ($signed(a) > $signed(b)) ? a : b;
            4'd9:  return (a < b) ? a : b;
            default: return (a > b) ? a : b;
        endcase
    endfunction

    task automatic req(input logic [3:0] op, input logic [31:0] addr, input logic [31:0] d,
                       input bit acq, input bit rel, input int pend, input string tag);
        int i;
        bit exp_err;
        logic [31:0] exp_data;
        int exp_lat;
        int exp_acc;
        int lat;
        int acc;
        bit got;
        i = int'(addr[7:2]);
        exp_err = (addr[1:0] != 2'b00) || (op > 4'd10);
        exp_data = 32'd0;
        if (exp_err) begin
            exp_lat = 1; exp_acc = 0;
        end else if (op == 4'd0) begin
            exp_data = ref_mem[i]; ref_held = 1; ref_idx = i;
            exp_lat = 3; exp_acc = 1;
        end else if (op == 4'd1) begin
            if (ref_held && ref_idx == i) begin
                ref_mem[i] = d; exp_data = 0; exp_lat = 3; exp_acc = 1;
            end else begin
                exp_data = 1; exp_lat = 2; exp_acc = 0;
            end
            ref_held = 0;
        end else begin
            exp_data = ref_mem[i];
            ref_mem[i] = combine(op, ref_mem[i], d);
            exp_lat = 4; exp_acc = 2;
        end
        if (rel && pend > 0 && !exp_err) exp_lat += pend + 1;

        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = addr; req_data = d;
        req_acq = acq; req_rel = rel; wr_pending = (pend > 0);
        lat = 0; acc = 0; got = 0;
        while (!got && lat < 60) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (lat == 1) req_valid = 0;
            if (wr_pending) begin
                chk(!mem_en, "R8", "memory access while writes pending", {31'd0, mem_en}, 0);
                if (lat == 1 + pend) wr_pending = 0;
            end
            if (mem_en) acc++;
            if (rsp_valid) got = 1;
            else chk(!req_ready, "R7", "ready while busy", {31'd0, req_ready}, 0);
        end
        chk(got, tag, "response seen", {31'd0, got}, 1);
        chk(lat == exp_lat, tag, "latency", lat, exp_lat);
        chk(rsp_data == exp_data, tag, "rsp_data", rsp_data, exp_data);
        chk(rsp_err == exp_err, tag, "rsp_err", {31'd0, rsp_err}, {31'd0, exp_err});
        chk(req_ready == !acq, "R7", "ready in response cycle", {31'd0, req_ready}, {31'd0, !acq});
        chk(acc == exp_acc, tag, "memory access count", acc, exp_acc);
        chk(mem[i] == ref_mem[i], tag, "memory word", mem[i], ref_mem[i]);
    endtask

    task automatic snoop(input logic [31:0] addr);
        if (ref_held && ref_idx == int'(addr[7:2])) ref_held = 0;
        @(negedge clk);
        snoop_valid = 1; snoop_waddr = addr[31:2];
        @(posedge clk);
        @(negedge clk);
        snoop_valid = 0;
    endtask

    initial begin
        for (int k = 0; k < 64; k++) begin
            mem[k] = 32'h1357_9BDF * (k + 1);
            ref_mem[k] = 32'h1357_9BDF * (k + 1);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_en, "R10", "outputs in reset",
            {29'd0, req_ready, rsp_valid, mem_en}, 32'h4);
        rst_n = 1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !mem_en, "R10", "outputs after reset",
            {29'd0, req_ready, rsp_valid, mem_en}, 32'h4);
        req(4'd1, 32'h10, 32'h1111_1111, 0, 0, 0, "R10");

        // reservation basics
        req(4'd0, 32'h20, 0, 0, 0, 0, "R1");
        req(4'd1, 32'h20, 32'hAAAA_5555, 0, 0, 0, "R2");
        req(4'd1, 32'h20, 32'h0BAD_0BAD, 0, 0, 0, "R3");
        req(4'd0, 32'h24, 0, 1, 0, 0, "R1");
        req(4'd1, 32'h28, 32'h2222_2222, 0, 0, 0, "R2");
        req(4'd1, 32'h24, 32'h3333_3333, 0, 0, 0, "R3");

        // snoop
        req(4'd0, 32'h30, 0, 0, 0, 0, "R1");
        snoop(32'h34);
        req(4'd1, 32'h30, 32'h4444_4444, 0, 0, 0, "R4");
        req(4'd0, 32'h30, 0, 0, 0, 0, "R1");
        snoop(32'h30);
        req(4'd1, 32'h30, 32'h5555_5555, 0, 0, 0, "R4");

        // atomic functions
        req(4'd2, 32'h40, 32'h8000_0001, 0, 0, 0, "R5");
        req(4'd7, 32'h40, 32'h0000_0001, 0, 0, 0, "R6");
        req(4'd9, 32'h40, 32'h0000_0001, 1, 0, 0, "R6");
        req(4'd8, 32'h40, 32'hFFFF_FFFF, 0, 0, 0, "R6");
        req(4'd10, 32'h40, 32'hFFFF_FFFE, 0, 0, 0, "R6");
        req(4'd2, 32'h44, 32'h7FFF_FFFF, 0, 0, 0, "R5");
        req(4'd8, 32'h44, 32'h8000_0000, 0, 0, 0, "R6");
        req(4'd10, 32'h44, 32'h8000_0000, 0, 0, 0, "R6");
        req(4'd7, 32'h44, 32'hFFFF_FFF0, 1, 0, 0, "R6");
        req(4'd9, 32'h44, 32'h7000_0000, 0, 0, 0, "R6");
        req(4'd3, 32'h48, 32'hFFFF_FFFF, 0, 0, 0, "R5");
        req(4'd3, 32'h48, 32'h8000_0000, 0, 0, 0, "R5");
        req(4'd4, 32'h4C, 32'h0F0F_F0F0, 0, 0, 0, "R5");
        req(4'd5, 32'h4C, 32'h1234_0000, 1, 0, 0, "R5");
        req(4'd6, 32'h4C, 32'hFFFF_FFFF, 0, 0, 0, "R5");

        // ordering
        req(4'd3, 32'h50, 32'd5, 0, 1, 3, "R8");
        req(4'd0, 32'h54, 0, 1, 1, 2, "R8");
        req(4'd1, 32'h54, 32'h6666_6666, 1, 1, 0, "R8");

        // errors
        req(4'd3, 32'h5A, 32'd7, 0, 0, 0, "R9");
        req(4'd12, 32'h5C, 32'd7, 1, 0, 0, "R9");
        req(4'd0, 32'h60, 0, 0, 0, 0, "R1");
        req(4'd1, 32'h61, 32'h7777_7777, 0, 0, 0, "R9");
        req(4'd1, 32'h60, 32'h8888_8888, 0, 0, 0, "R9");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule